// File: doc/BRIEF.md
# Frame Exchange Handshake Sequencer

This block is the control sequencer that moves image frames between a capture path and an external compression processor. After reset it stays idle until a capture command arrives. It then passes preprocessed pixels into an outbound FIFO and raises a DMA request toward the processor once that FIFO reports half full. When the processor signals that compression is done, the block drains the compressed frame from an inbound FIFO into a host-side buffer. Finally it samples an encode-valid flag to decide whether to start another frame or to send an end notice.

The FIFOs, the filter, the memory controller and the host interface are all outside the block. They connect through plain valid/ready and flag ports, and the data paths pass through without change. The frame length on the capture side is a parameter. The compressed frame length is a count that is loaded at the start of each readout. A synchronous soft reset returns the sequencer to idle from any state.

Top module: `frame_xchg_seq`

## Requirements
- R1: After reset, every output is low. Until `acq_cmd` is seen high while idle, pixels on `pix_valid` are not written (`ofifo_wr_en` stays 0).
- R2: While capturing, each cycle with `pix_valid` high and `ofifo_full` low produces `ofifo_wr_en` high in the same cycle, with `ofifo_wr_data` equal to `pix_data`. Capture ends after exactly FRAME_PIX valid pixels, counting dropped ones, and later pixels are not written.
- R3: A valid pixel that arrives while `ofifo_full` is high is not written. `overflow` goes high on the next cycle and stays high until `rst` or `soft_rst`.
- R4: `dma_req` rises on the clock edge after `ofifo_half` is seen high during capture. It stays high until the frame is fully captured and `ofifo_empty` is high, and it falls on the edge after that.
- R5: `cmp_irq` passes through a two-flop synchroniser and only its rising edge counts. One rising edge seen while waiting for compression starts exactly one readout. Edges at any other time, and a level that stays high, start nothing.
- R6: During readout a word moves only in cycles where `ififo_valid` and `hbuf_ready` are both high. In those cycles `ififo_rd_en` and `hbuf_wr_en` are high together and `hbuf_wr_data` equals `ififo_data`. Exactly `eof_count` words move, where `eof_count` is the value captured when the readout starts.
- R7: After the last word, if `encode_valid` is high, the next capture starts without a new `acq_cmd`.
- R8: After the last word, if `encode_valid` is low, `end_notice` is high for exactly one cycle and the sequencer then returns to idle.
- R9: `soft_rst` sends the sequencer to idle on the next edge from any state and clears `dma_req` and `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous return to idle |
| acq_cmd | input | 1 | Start-of-capture command |
| pix_valid | input | 1 | Preprocessed pixel present |
| pix_data | input | PIX_W | Preprocessed pixel |
| ofifo_full | input | 1 | Outbound FIFO full |
| ofifo_half | input | 1 | Outbound FIFO at or above half |
| ofifo_empty | input | 1 | Outbound FIFO empty |
| ofifo_wr_en | output | 1 | Outbound FIFO write strobe |
| ofifo_wr_data | output | PIX_W | Outbound FIFO write data |
| dma_req | output | 1 | DMA request to the processor |
| cmp_irq | input | 1 | Asynchronous compression-done interrupt |
| eof_count | input | CNT_W | Compressed words in the coming frame |
| ififo_valid | input | 1 | Inbound FIFO has data |
| ififo_data | input | DATA_W | Inbound FIFO read data |
| ififo_rd_en | output | 1 | Inbound FIFO read strobe |
| hbuf_ready | input | 1 | Host buffer can accept a word |
| hbuf_wr_en | output | 1 | Host buffer write strobe |
| hbuf_wr_data | output | DATA_W | Host buffer write data |
| encode_valid | input | 1 | Continue with another frame |
| end_notice | output | 1 | One-cycle end notice to the processor |
| overflow | output | 1 | Sticky dropped-pixel flag |

## Verification
The bench drops a pixel while the FIFO is full and feeds more valid pixels than one frame holds. A design that counted only the written pixels would take an extra pixel, and one that ignored the full flag would write into a full FIFO. It holds the interrupt high through a capture and across a whole readout. A level-triggered design would start a readout too early or read two frames, and a design without an edge detector would retrigger. The host-buffer ready signal is dropped on a regular pattern, so a sequencer that reads the inbound FIFO without waiting for ready shows up as a word count or data mismatch. It also checks that DMA requests are not released before the FIFO is empty, that the end notice is a single pulse, and that soft reset clears the sticky flags in the middle of a capture.

// File: rtl/frame_xchg_pkg.sv
package frame_xchg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_CAPTURE  = 3'd1,
        ST_WAIT_CMP = 3'd2,
        ST_READOUT  = 3'd3,
        ST_CHECK    = 3'd4,
        ST_DONE     = 3'd5
    } seq_state_t;

    localparam int IRQ_SYNC_STAGES = 2;

    function automatic logic handshake(input logic valid, input logic ready);
        return valid & ready;
    endfunction

endpackage

// File: rtl/fx_irq_sync.sv
module fx_irq_sync #(
    parameter int STAGES = frame_xchg_pkg::IRQ_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/fx_down_counter.sv
module fx_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (dec && remain != '0)
            remain <= remain - W'(1);
    end

    // last word pending: remaining count is 0 or 1
    assign last = (remain[W-1:1] == '0);
endmodule

// File: rtl/frame_xchg_seq.sv
module frame_xchg_seq
    import frame_xchg_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int DATA_W    = 8,
    parameter int FRAME_PIX = 16,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              acq_cmd,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              ofifo_full,
    input  logic              ofifo_half,
    input  logic              ofifo_empty,
    output logic              ofifo_wr_en,
    output logic [PIX_W-1:0]  ofifo_wr_data,
    output logic              dma_req,
    input  logic              cmp_irq,
    input  logic [CNT_W-1:0]  eof_count,
    input  logic              ififo_valid,
    input  logic [DATA_W-1:0] ififo_data,
    output logic              ififo_rd_en,
    input  logic              hbuf_ready,
    output logic              hbuf_wr_en,
    output logic [DATA_W-1:0] hbuf_wr_data,
    input  logic              encode_valid,
    output logic              end_notice,
    output logic              overflow
);
    localparam int PIX_CNT_W = $clog2(FRAME_PIX + 1);

    seq_state_t state, state_nxt;
    logic irq_rise;
    logic pix_take, rd_fire;
    logic pix_load, pix_last;
    logic rd_load, rd_last;

    fx_irq_sync u_irq_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (cmp_irq),
        .rise     (irq_rise)
    );

    assign pix_take = (state == ST_CAPTURE) && pix_valid;
    assign rd_fire  = (state == ST_READOUT) && handshake(ififo_valid, hbuf_ready);
    assign pix_load = ((state == ST_IDLE) && acq_cmd) ||
                      ((state == ST_CHECK) && encode_valid);
    assign rd_load  = (state == ST_WAIT_CMP) && irq_rise;

    fx_down_counter #(.W(PIX_CNT_W)) u_pix_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (pix_load),
        .load_val (PIX_CNT_W'(FRAME_PIX)),
        .dec      (pix_take),
        .last     (pix_last)
    );

    fx_down_counter #(.W(CNT_W)) u_rd_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (rd_load),
        .load_val (eof_count),
        .dec      (rd_fire),
        .last     (rd_last)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:     if (acq_cmd)            state_nxt = ST_CAPTURE;
            ST_CAPTURE:  if (pix_take && pix_last) state_nxt = ST_WAIT_CMP;
            ST_WAIT_CMP: if (irq_rise)           state_nxt = ST_READOUT;
            ST_READOUT:  if (rd_fire && rd_last) state_nxt = ST_CHECK;
            ST_CHECK:    state_nxt = encode_valid ? ST_CAPTURE : ST_DONE;
            ST_DONE:     state_nxt = ST_IDLE;
            default:     state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            state    <= ST_IDLE;
            dma_req  <= 1'b0;
            overflow <= 1'b0;
        end else begin
            state <= state_nxt;
            if (pix_take && ofifo_full)
                overflow <= 1'b1;
            if ((state == ST_CAPTURE) && ofifo_half)
                dma_req <= 1'b1;
            else if ((state == ST_IDLE) ||
                     ((state == ST_WAIT_CMP) && ofifo_empty))
                dma_req <= 1'b0;
        end
    end

    assign ofifo_wr_en   = pix_take && !ofifo_full;
    assign ofifo_wr_data = pix_data;
    assign ififo_rd_en   = rd_fire;
    assign hbuf_wr_en    = rd_fire;
    assign hbuf_wr_data  = ififo_data;
    assign end_notice    = (state == ST_DONE);
endmodule

// File: rtl/frame_xchg_sva.sv
module frame_xchg_sva
    import frame_xchg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       soft_rst,
    input logic       ofifo_full,
    input logic       ofifo_half,
    input logic       ofifo_wr_en,
    input logic       overflow,
    input logic       dma_req,
    input logic       ififo_valid,
    input logic       ififo_rd_en,
    input logic       hbuf_ready,
    input logic       hbuf_wr_en,
    input logic       end_notice,
    input seq_state_t state
);
    // R3: a full FIFO is never written
    p_full_blocks_write_r3: assert property (@(posedge clk) disable iff (rst)
        ofifo_full |-> !ofifo_wr_en);

    // R3: overflow flag holds until a reset
    p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (overflow && !soft_rst) |=> overflow);

    // R4: request only rises after the half flag was seen
    p_dma_rise_after_half_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_req) |-> $past(ofifo_half));

    // R5: capture writes and readout reads never coincide
    p_no_rw_overlap_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ofifo_wr_en, ififo_rd_en}));

    // R6: a read only with both sides ready, mirrored into the host buffer
    p_read_gated_r6: assert property (@(posedge clk) disable iff (rst)
        ififo_rd_en |-> (ififo_valid && hbuf_ready && hbuf_wr_en));

    // R8: end notice is a single pulse followed by idle
    p_end_single_r8: assert property (@(posedge clk) disable iff (rst)
        end_notice |=> (!end_notice && state == ST_IDLE));

    // R9: soft reset lands in idle with flags cleared
    p_soft_idle_r9: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (state == ST_IDLE && !dma_req && !overflow));
endmodule

bind frame_xchg_seq frame_xchg_sva u_sva (
    .clk         (clk),
    .rst         (rst),
    .soft_rst    (soft_rst),
    .ofifo_full  (ofifo_full),
    .ofifo_half  (ofifo_half),
    .ofifo_wr_en (ofifo_wr_en),
    .overflow    (overflow),
    .dma_req     (dma_req),
    .ififo_valid (ififo_valid),
    .ififo_rd_en (ififo_rd_en),
    .hbuf_ready  (hbuf_ready),
    .hbuf_wr_en  (hbuf_wr_en),
    .end_notice  (end_notice),
    .state       (state)
);

// File: tb/frame_xchg_seq_tb.sv
module frame_xchg_seq_tb;
    localparam int PIX_W = 8, DATA_W = 8, FRAME_PIX = 16, CNT_W = 16;

    logic clk = 1'b0;
    logic rst, soft_rst, acq_cmd, pix_valid, ofifo_full, ofifo_half, ofifo_empty;
    logic [PIX_W-1:0] pix_data;
    logic ofifo_wr_en, dma_req, cmp_irq, ififo_valid, ififo_rd_en, hbuf_ready;
    logic hbuf_wr_en, encode_valid, end_notice, overflow;
    logic [PIX_W-1:0] ofifo_wr_data;
    logic [CNT_W-1:0] eof_count;
    logic [DATA_W-1:0] ififo_data, hbuf_wr_data;

    int n_checks = 0, n_fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    frame_xchg_seq #(.PIX_W(PIX_W), .DATA_W(DATA_W), .FRAME_PIX(FRAME_PIX), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .acq_cmd(acq_cmd),
        .pix_valid(pix_valid), .pix_data(pix_data), .ofifo_full(ofifo_full),
        .ofifo_half(ofifo_half), .ofifo_empty(ofifo_empty), .ofifo_wr_en(ofifo_wr_en),
        .ofifo_wr_data(ofifo_wr_data), .dma_req(dma_req), .cmp_irq(cmp_irq),
        .eof_count(eof_count), .ififo_valid(ififo_valid), .ififo_data(ififo_data),
        .ififo_rd_en(ififo_rd_en), .hbuf_ready(hbuf_ready), .hbuf_wr_en(hbuf_wr_en),
        .hbuf_wr_data(hbuf_wr_data), .encode_valid(encode_valid),
        .end_notice(end_notice), .overflow(overflow)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_pixels(input int n, input int full_at, input int half_at, output int writes);
        writes = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_valid  = 1'b1;
            pix_data   = 8'(i * 7 + 3);
            ofifo_full = (i == full_at);
            if (i == half_at) ofifo_half = 1'b1;
            #1;
            if (ofifo_wr_en) begin
                writes++;
                if (ofifo_wr_data != pix_data)
                    chk("R2", "write data", int'(ofifo_wr_data), int'(pix_data));
            end
            if (i == full_at) chk("R3", "write while full", int'(ofifo_wr_en), 0);
            if (full_at >= 0 && i == full_at + 1) chk("R3", "overflow set", int'(overflow), 1);
            if (half_at >= 0 && i == half_at) chk("R4", "dma before half edge", int'(dma_req), 0);
            if (half_at >= 0 && i == half_at + 1) chk("R4", "dma after half", int'(dma_req), 1);
        end
        @(negedge clk);
        pix_valid  = 1'b0;
        ofifo_full = 1'b0;
    endtask

    task automatic send_cmd();
        @(negedge clk); acq_cmd = 1'b1;
        @(negedge clk); acq_cmd = 1'b0;
    endtask

    task automatic run_readout(input int eof, input bit enc, input bit hold_irq,
                               output int words, output int ends);
        int bad_ready = 0;
        int bad_data = 0;
        words = 0; ends = 0;
        encode_valid = enc;
        eof_count    = CNT_W'(eof);
        @(negedge clk); cmp_irq = 1'b1;
        for (int c = 0; c < 50; c++) begin
            @(negedge clk);
            if (!hold_irq && c == 2) cmp_irq = 1'b0;
            ififo_valid = 1'b1;
            hbuf_ready  = (c % 3 != 1);
            ififo_data  = 8'(c + 100);
            #1;
            if (ififo_rd_en) begin
                words++;
                if (!hbuf_ready) bad_ready++;
                if (!hbuf_wr_en || hbuf_wr_data != ififo_data) bad_data++;
            end
            if (end_notice) ends++;
        end
        chk("R6", "read without ready", bad_ready, 0);
        chk("R6", "host write mismatch", bad_data, 0);
        ififo_valid = 1'b0;
        cmp_irq     = 1'b0;
    endtask

    task automatic t_reset();
        int w;
        chk("R1", "wr_en after reset", int'(ofifo_wr_en), 0);
        chk("R1", "dma after reset", int'(dma_req), 0);
        chk("R1", "end_notice after reset", int'(end_notice), 0);
        chk("R1", "overflow after reset", int'(overflow), 0);
        chk("R1", "rd_en after reset", int'(ififo_rd_en), 0);
        run_pixels(4, -1, -1, w);
        chk("R1", "writes without command", w, 0);
    endtask

    task automatic t_first_frame();
        int w;
        ofifo_empty = 1'b0;
        send_cmd();
        run_pixels(FRAME_PIX + 4, 4, 8, w);
        chk("R2", "writes in frame with one drop", w, FRAME_PIX - 1);
        chk("R3", "overflow still set", int'(overflow), 1);
        chk("R4", "dma held until empty", int'(dma_req), 1);
        @(negedge clk); ofifo_empty = 1'b1;
        @(negedge clk); #1;
        chk("R4", "dma released on empty", int'(dma_req), 0);
    endtask

    task automatic t_readout_continue();
        int words, ends, w;
        run_readout(5, 1'b1, 1'b0, words, ends);
        chk("R6", "words moved", words, 5);
        chk("R7", "no end notice when valid", ends, 0);
        ofifo_empty = 1'b0;
        ofifo_half  = 1'b0;
        cmp_irq = 1'b1;
        run_pixels(FRAME_PIX, -1, -1, w);
        chk("R7", "second frame without command", w, FRAME_PIX);
        cmp_irq = 1'b0;
    endtask

    task automatic t_quiet_wait();
        int reads = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            ififo_valid = 1'b1; hbuf_ready = 1'b1;
            #1;
            if (ififo_rd_en) reads++;
        end
        ififo_valid = 1'b0;
        chk("R5", "edge during capture ignored", reads, 0);
    endtask

    task automatic t_readout_end();
        int words, ends, w;
        run_readout(3, 1'b0, 1'b1, words, ends);
        chk("R5", "held interrupt reads one frame", words, 3);
        chk("R8", "end notice pulses", ends, 1);
        run_pixels(6, -1, -1, w);
        chk("R8", "idle after end", w, 0);
    endtask

    task automatic t_soft_reset();
        int w;
        send_cmd();
        run_pixels(5, 2, 1, w);
        chk("R9", "writes before soft reset", w, 4);
        chk("R3", "overflow before soft reset", int'(overflow), 1);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0; #1;
        chk("R9", "overflow cleared", int'(overflow), 0);
        chk("R9", "dma cleared", int'(dma_req), 0);
        ofifo_half = 1'b0;
        run_pixels(4, -1, -1, w);
        chk("R9", "no capture after soft reset", w, 0);
    endtask

    initial begin
        rst = 1'b1; soft_rst = 1'b0; acq_cmd = 1'b0; pix_valid = 1'b0; pix_data = '0;
        ofifo_full = 1'b0; ofifo_half = 1'b0; ofifo_empty = 1'b1; cmp_irq = 1'b0;
        eof_count = '0; ififo_valid = 1'b0; ififo_data = '0; hbuf_ready = 1'b0;
        encode_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_first_frame();
        t_readout_continue();
        t_quiet_wait();
        t_readout_end();
        t_soft_reset();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(10 * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule